// File: doc/BRIEF.md
# PS/2 Device Link Controller

This block is the peripheral end of a PS/2 two-wire link. The peripheral always generates the clock. Both lines are open-drain. For each line the block takes a sensed level as input and gives a pull-low enable as output. A byte handshake feeds bytes in for sending to the host. Bytes that the host sends come out on a strobe, with flags for parity and framing errors. The block does not interpret host commands.

Each clock half-period is a fixed number of pulses of `tick_i`. With a 1 µs tick the default gives 40 µs halves. While the link is idle, the block samples both lines at the end of every half-period:
- If the host holds the clock low, nothing happens.
- If the clock is high and data is low, the host has a byte to send, and the block clocks it in.
- If both lines are high and a byte is waiting, the block sends that byte.

While it sends, the block checks the clock line once per high half. If the host pulls the clock low before the tenth rising edge, the block lets go of both lines and keeps the byte for a later attempt.

Top module: `ps2_dev_link`

## Requirements
- R1: After reset both pull enables are low, `tx_ready_o` is high and no output strobe is active.
- R2: A sent frame has 11 clocks. Its bits are: a start bit of 0, data bits 0 to 7, an odd parity bit and a stop bit of 1. The host reads each bit on a falling clock edge. The data pull is set while the clock is released and does not change while the block holds the clock low.
- R3: Every high half and every low half of a generated clock lasts exactly HALF_TICKS tick pulses.
- R4: While the host holds the clock low, no frame starts. A byte that is waiting stays in the block.
- R5: A frame starts only if both lines are sensed high at the end of an idle half-period. If the clock is high and data is low at that point, the block receives, even when a byte is waiting to be sent.
- R6: The clock line is sensed at the end of each high half before clocks 1 to 10. If it is low there, the block releases both lines and gives no `tx_done_o`. It later sends the same byte again in full.
- R7: `tx_done_o` pulses once, in the cycle the block releases clock 10. From then on the byte counts as sent, and a host clock-low during clock 11 does not cause it to be sent again.
- R8: On receive, the block samples data at the end of each low half. The order is data bits 0 to 7, then parity, then stop. If the stop bit is high, the block pulls data low and gives one more clock (clock 11). It then releases both lines and pulses `rx_valid_o` with the byte.
- R9: `rx_perr_o` is high together with `rx_valid_o` exactly when the nine received data and parity bits hold an even number of ones.
- R10: If the stop bit is sampled low, the block keeps clocking until it samples data high. It then gives the pull-low line-control clock and pulses `rx_ferr_o` instead of `rx_valid_o`.
- R11: `tx_ready_o` is high whenever no byte is held. A byte is taken on a cycle with `tx_valid_i` and `tx_ready_o` both high. `tx_ready_o` then stays low until that byte counts as sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse; HALF_TICKS pulses per clock half |
| ps2_clk_i | input | 1 | Sensed level of the clock line |
| ps2_dat_i | input | 1 | Sensed level of the data line |
| ps2_clk_pull_o | output | 1 | Pull the clock line low when high |
| ps2_dat_pull_o | output | 1 | Pull the data line low when high |
| tx_valid_i | input | 1 | A byte is offered for sending |
| tx_byte_i | input | 8 | Byte offered for sending |
| tx_ready_o | output | 1 | The block can take a byte |
| tx_done_o | output | 1 | One-cycle pulse: the held byte counts as sent |
| rx_valid_o | output | 1 | One-cycle pulse: a host byte was received |
| rx_byte_o | output | 8 | Last received host byte |
| rx_perr_o | output | 1 | Parity error, valid with rx_valid_o |
| rx_ferr_o | output | 1 | One-cycle pulse: framing error, resend wanted |

## Verification
The bench builds the block with HALF_TICKS = 5 and a tick on every second clock, so every clock half is exactly 10 system cycles. A full frame then takes a few hundred cycles. This short period lets the bench cover in one run:
- inhibit;
- early and late contention with a retry;
- receive with good parity, bad parity and a held-low stop bit;
- the priority of receive over a waiting byte.

SYNC_STAGES stays at 2. The fixed 10-cycle half makes the length of every generated clock edge an exact value that can be compared.

// File: rtl/ps2_dev_pkg.sv
package ps2_dev_pkg;

  localparam int FRAME_BITS  = 11;
  localparam int BIT_W       = $clog2(FRAME_BITS);
  // index of the clock whose rising edge commits a sent byte
  localparam int COMMIT_BIT  = FRAME_BITS - 2;
  // index of the stop bit sampled from the host
  localparam int HOST_STOP   = FRAME_BITS - 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_RX,
    ST_RXW,
    ST_ACK
  } link_st_e;

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= g_stage[g-1].q;
      end
    end
  end

  assign line_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/ps2_half_timer.sv
module ps2_half_timer #(
  parameter int HALF_TICKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic expire_o
);

  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire_o = tick_i && (cnt_q == LAST) && !restart_i;
    cnt_d    = cnt_q;
    if (restart_i)     cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ps2_dev_link.sv
module ps2_dev_link
  import ps2_dev_pkg::*;
#(
  parameter int HALF_TICKS  = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_pull_o,
  output logic       ps2_dat_pull_o,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_ready_o,
  output logic       tx_done_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_perr_o,
  output logic       rx_ferr_o
);

  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] COMMIT_IDX = BIT_W'(COMMIT_BIT);
  localparam logic [BIT_W-1:0] STOP_IDX   = BIT_W'(HOST_STOP);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  link_st_e              st_q, st_d;
  logic                  ph_lo_q, ph_lo_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic [HOST_STOP:0]    rxsh_q, rxsh_d;
  logic [7:0]            pend_q, pend_d;
  logic                  pend_vld_q, pend_vld_d;
  logic                  clk_pull_q, clk_pull_d;
  logic                  dat_pull_q, dat_pull_d;
  logic                  ferr_q, ferr_d;
  logic                  tx_done_q, tx_done_d;
  logic                  rx_valid_q, rx_valid_d;
  logic                  rx_perr_q, rx_perr_d;
  logic                  rx_ferr_q, rx_ferr_d;
  logic [7:0]            rx_byte_q, rx_byte_d;

  logic [1:0] line_s;
  logic       clk_s, dat_s;
  logic       expire, tmr_restart;

  ps2_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .line_i ({ps2_dat_i, ps2_clk_i}),
    .line_o (line_s)
  );
  assign clk_s = line_s[0];
  assign dat_s = line_s[1];

  // host inhibit holds the idle timer at zero: a full half follows release
  assign tmr_restart = (st_q == ST_IDLE) && !clk_s;

  ps2_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .tick_i    (tick_i),
    .restart_i (tmr_restart),
    .expire_o  (expire)
  );

  always_comb begin
    st_d       = st_q;
    ph_lo_d    = ph_lo_q;
    bit_d      = bit_q;
    frm_d      = frm_q;
    rxsh_d     = rxsh_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    clk_pull_d = clk_pull_q;
    dat_pull_d = dat_pull_q;
    ferr_d     = ferr_q;
    rx_byte_d  = rx_byte_q;
    tx_done_d  = 1'b0;
    rx_valid_d = 1'b0;
    rx_perr_d  = 1'b0;
    rx_ferr_d  = 1'b0;

    if (tx_valid_i && !pend_vld_q) begin
      pend_d     = tx_byte_i;
      pend_vld_d = 1'b1;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (expire && clk_s) begin
          if (!dat_s) begin
            st_d    = ST_RX;
            ph_lo_d = 1'b0;
            bit_d   = '0;
            ferr_d  = 1'b0;
          end else if (pend_vld_q) begin
            st_d       = ST_TX;
            ph_lo_d    = 1'b0;
            bit_d      = '0;
            frm_d      = {1'b1, odd_par(pend_q), pend_q, 1'b0};
            dat_pull_d = 1'b1;
          end
        end
      end

      ST_TX: begin
        if (expire) begin
          if (!ph_lo_q) begin
            if ((bit_q <= COMMIT_IDX) && !clk_s) begin
              st_d       = ST_IDLE;
              dat_pull_d = 1'b0;
            end else begin
              clk_pull_d = 1'b1;
              ph_lo_d    = 1'b1;
            end
          end else begin
            clk_pull_d = 1'b0;
            ph_lo_d    = 1'b0;
            if (bit_q == COMMIT_IDX) begin
              tx_done_d  = 1'b1;
              pend_vld_d = 1'b0;
            end
            if (bit_q == LAST_BIT) begin
              st_d       = ST_IDLE;
              dat_pull_d = 1'b0;
            end else begin
              bit_d      = bit_q + 1'b1;
              dat_pull_d = ~frm_q[bit_q + 1'b1];
            end
          end
        end
      end

      ST_RX, ST_RXW: begin
        if (expire) begin
          if (!ph_lo_q) begin
            clk_pull_d = 1'b1;
            ph_lo_d    = 1'b1;
          end else begin
            clk_pull_d = 1'b0;
            ph_lo_d    = 1'b0;
            if (st_q == ST_RX) begin
              rxsh_d[bit_q] = dat_s;
              if (bit_q == STOP_IDX) begin
                if (dat_s) begin
                  st_d       = ST_ACK;
                  dat_pull_d = 1'b1;
                end else begin
                  st_d   = ST_RXW;
                  ferr_d = 1'b1;
                end
              end else begin
                bit_d = bit_q + 1'b1;
              end
            end else if (dat_s) begin
              st_d       = ST_ACK;
              dat_pull_d = 1'b1;
            end
          end
        end
      end

      ST_ACK: begin
        if (expire) begin
          if (!ph_lo_q) begin
            clk_pull_d = 1'b1;
            ph_lo_d    = 1'b1;
          end else begin
            clk_pull_d = 1'b0;
            dat_pull_d = 1'b0;
            ph_lo_d    = 1'b0;
            st_d       = ST_IDLE;
            if (ferr_q) begin
              rx_ferr_d = 1'b1;
            end else begin
              rx_valid_d = 1'b1;
              rx_perr_d  = ~(^rxsh_q[8:0]);
              rx_byte_d  = rxsh_q[7:0];
            end
          end
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      st_q       <= ST_IDLE;
      ph_lo_q    <= 1'b0;
      bit_q      <= '0;
      frm_q      <= '1;
      rxsh_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      clk_pull_q <= 1'b0;
      dat_pull_q <= 1'b0;
      ferr_q     <= 1'b0;
      tx_done_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_perr_q  <= 1'b0;
      rx_ferr_q  <= 1'b0;
      rx_byte_q  <= '0;
    end else begin
      st_q       <= st_d;
      ph_lo_q    <= ph_lo_d;
      bit_q      <= bit_d;
      frm_q      <= frm_d;
      rxsh_q     <= rxsh_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      clk_pull_q <= clk_pull_d;
      dat_pull_q <= dat_pull_d;
      ferr_q     <= ferr_d;
      tx_done_q  <= tx_done_d;
      rx_valid_q <= rx_valid_d;
      rx_perr_q  <= rx_perr_d;
      rx_ferr_q  <= rx_ferr_d;
      rx_byte_q  <= rx_byte_d;
    end
  end

  assign ps2_clk_pull_o = clk_pull_q;
  assign ps2_dat_pull_o = dat_pull_q;
  assign tx_ready_o     = !pend_vld_q;
  assign tx_done_o      = tx_done_q;
  assign rx_valid_o     = rx_valid_q;
  assign rx_byte_o      = rx_byte_q;
  assign rx_perr_o      = rx_perr_q;
  assign rx_ferr_o      = rx_ferr_q;

  // R4
  idle_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (st_q == ST_IDLE && !clk_s) |=> (st_q == ST_IDLE && !clk_pull_q));

  // R2
  dat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (clk_pull_q && $past(clk_pull_q)) |-> $stable(dat_pull_q));

  // R7
  done_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    tx_done_q |-> ($fell(clk_pull_q) && st_q == ST_TX));

  // R8
  rx_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (rx_valid_q || rx_ferr_q) |-> ($fell(clk_pull_q) && $past(dat_pull_q)));

  // R11
  ready_take_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R6
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (st_q == ST_IDLE && $past(st_q) == ST_TX) |-> (!clk_pull_q && !dat_pull_q));

endmodule

// File: tb/test_ps2_dev_link.sv
module test_ps2_dev_link;

  localparam int HALF_TICKS = 5;
  localparam int HP = 2 * HALF_TICKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic host_clk_pull = 1'b0;
  logic host_dat_pull = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic dev_cp, dev_dp, tx_ready, tx_done, rx_valid, rx_perr, rx_ferr;
  logic [7:0] rx_byte;
  wire clk_line = ~(dev_cp | host_clk_pull);
  wire dat_line = ~(dev_dp | host_dat_pull);

  always #4 clk = ~clk;
  always @(negedge clk) tick = ~tick;

  ps2_dev_link #(.HALF_TICKS(HALF_TICKS), .SYNC_STAGES(2)) i_ps2_dev_link (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_pull_o(dev_cp), .ps2_dat_pull_o(dev_dp),
    .tx_valid_i(tx_valid), .tx_byte_i(tx_byte),
    .tx_ready_o(tx_ready), .tx_done_o(tx_done),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural host-side reference: decodes what the host would read
  int dev_falls = 0, since_edge = 1000, frames_ok = 0, done_cnt = 0;
  int rxv_cnt = 0, rxf_cnt = 0;
  bit prev_cp = 0, prev_dp = 0, dat_moved = 0, last_low_dat = 0;
  bit host_sending = 0, last_perr = 0;
  logic [7:0] last_rx = 8'h00;
  logic bitsq[$];
  logic [7:0] exp_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      since_edge++;
      if (dev_cp != prev_cp) begin
        if (since_edge < 2 * HP) chk(since_edge == HP, "R3", "half length", since_edge, HP);
        since_edge = 0;
        if (dev_cp) begin
          dev_falls++;
          dat_moved = 0;
          if (!host_sending) bitsq.push_back(~dev_dp);
        end else begin
          last_low_dat = prev_dp;
          chk(!dat_moved, "R2", "data moved while clock low", dat_moved, 0);
        end
      end else if (dev_cp && dev_dp != prev_dp) begin
        dat_moved = 1;
      end
      if (bitsq.size() == 11) begin
        logic [7:0] got, want;
        logic par;
        for (int i = 0; i < 8; i++) got[i] = bitsq[i+1];
        par = bitsq[9];
        want = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(got === want, "R2", "sent byte", got, want);
        chk(bitsq[0] == 0 && bitsq[10] == 1 && (^{par, got}) == 1'b1,
            "R2", "start/parity/stop", {bitsq[0], par, bitsq[10]}, {1'b0, ~^got, 1'b1});
        frames_ok++;
        bitsq.delete();
      end
      if (tx_done) done_cnt++;
      if (rx_valid) begin rxv_cnt++; last_rx = rx_byte; last_perr = rx_perr; end
      if (rx_ferr) rxf_cnt++;
      prev_cp = dev_cp;
      prev_dp = dev_dp;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_falls(input int target);
    int t = 0;
    while (dev_falls < target && t < 3000) begin @(negedge clk); t++; end
    if (dev_falls < target) chk(0, "R8", "clock timeout", dev_falls, target);
  endtask

  task automatic wait_done(input int target, input string req);
    int t = 0;
    while (done_cnt < target && t < 5000) begin @(negedge clk); t++; end
    chk(done_cnt >= target, req, "tx_done count", done_cnt, target);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_byte  = b;
    exp_q.push_back(b);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b, input bit good_par, input int extra);
    logic [9:0] hb;
    int base, rv, rf, t;
    host_sending = 1;
    bitsq.delete();
    hb = {(extra == 0), (good_par ? ~^b : ^b), b};
    host_clk_pull = 1'b1;
    wait_cycles(30);
    host_dat_pull = 1'b1;
    wait_cycles(2);
    base = dev_falls;
    rv = rxv_cnt;
    rf = rxf_cnt;
    host_clk_pull = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      wait_falls(base + k);
      host_dat_pull = ~hb[k-1];
    end
    for (int j = 1; j <= extra; j++) begin
      wait_falls(base + 10 + j);
      if (j == extra) host_dat_pull = 1'b0;
    end
    t = 0;
    while (rxv_cnt == rv && rxf_cnt == rf && t < 2000) begin @(negedge clk); t++; end
    chk(dev_falls - base == 11 + extra, (extra > 0) ? "R10" : "R8", "clocks in receive",
        dev_falls - base, 11 + extra);
    chk(last_low_dat == 1, "R8", "line-control bit pulled low", last_low_dat, 1);
    host_sending = 0;
    bitsq.delete();
  endtask

  initial begin
    int d0, f0, r0;
    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(6);
    // R1 reset state
    chk(dev_cp == 0 && dev_dp == 0, "R1", "pulls after reset", {dev_cp, dev_dp}, 0);
    chk(tx_ready == 1 && !tx_done && !rx_valid && !rx_ferr, "R1", "ready/strobes",
        {tx_ready, tx_done, rx_valid, rx_ferr}, 4'b1000);

    // R2 R11 plain sends with several data patterns
    push(8'hA5);
    chk(tx_ready == 0, "R11", "ready low while held", tx_ready, 0);
    wait_done(1, "R2");
    chk(tx_ready == 1, "R11", "ready after done", tx_ready, 1);
    push(8'h00);
    push(8'hFF);
    wait_done(3, "R2");
    wait_cycles(40);
    chk(frames_ok == 3, "R2", "frames decoded", frames_ok, 3);

    // R4 inhibit
    host_clk_pull = 1'b1;
    wait_cycles(20);
    f0 = dev_falls;
    push(8'h96);
    wait_cycles(300);
    chk(dev_falls == f0, "R4", "no clocks under inhibit", dev_falls, f0);
    chk(tx_ready == 0, "R4", "byte still held", tx_ready, 0);
    host_clk_pull = 1'b0;
    wait_done(4, "R4");
    wait_cycles(40);
    chk(frames_ok == 4, "R4", "held byte sent after release", frames_ok, 4);

    // R6 early contention and retry
    d0 = done_cnt;
    f0 = dev_falls;
    push(8'h3C);
    wait_falls(f0 + 4);
    while (dev_cp) @(negedge clk);
    host_clk_pull = 1'b1;
    wait_cycles(HP + 5);
    chk(dev_cp == 0 && dev_dp == 0, "R6", "lines released", {dev_cp, dev_dp}, 0);
    chk(done_cnt == d0 && tx_ready == 0, "R6", "no done, byte kept",
        {done_cnt - d0, 1'(tx_ready)}, 0);
    bitsq.delete();
    wait_cycles(100);
    host_clk_pull = 1'b0;
    wait_done(d0 + 1, "R6");
    wait_cycles(40);
    chk(frames_ok == 5, "R6", "retried frame decoded", frames_ok, 5);

    // R7 contention after clock 10 does not resend
    d0 = done_cnt;
    push(8'h5E);
    wait_done(d0 + 1, "R7");
    host_clk_pull = 1'b1;
    wait_cycles(60);
    host_clk_pull = 1'b0;
    f0 = dev_falls;
    wait_cycles(400);
    chk(dev_falls == f0 && done_cnt == d0 + 1, "R7", "no resend", dev_falls - f0, 0);
    chk(frames_ok == 6 && exp_q.size() == 0, "R7", "frame complete", frames_ok, 6);

    // R8 R9 receive, good parity
    r0 = rxv_cnt;
    host_send(8'h5A, 1, 0);
    chk(rxv_cnt == r0 + 1 && last_rx == 8'h5A, "R8", "received byte", last_rx, 8'h5A);
    chk(last_perr == 0, "R9", "no parity error", last_perr, 0);
    wait_cycles(30);
    host_send(8'hC3, 1, 0);
    chk(last_rx == 8'hC3 && last_perr == 0, "R8", "second byte", last_rx, 8'hC3);
    wait_cycles(30);

    // R9 bad parity
    host_send(8'h17, 0, 0);
    chk(last_rx == 8'h17 && rxv_cnt == r0 + 3, "R9", "byte with bad parity", last_rx, 8'h17);
    chk(last_perr == 1, "R9", "parity error flagged", last_perr, 1);
    wait_cycles(30);

    // R10 framing error: stop held low for two more clocks
    r0 = rxv_cnt;
    f0 = rxf_cnt;
    host_send(8'h81, 1, 2);
    chk(rxf_cnt == f0 + 1 && rxv_cnt == r0, "R10", "resend flagged, no byte",
        rxf_cnt - f0, 1);
    wait_cycles(30);

    // R5 receive wins over a waiting byte
    host_clk_pull = 1'b1;
    wait_cycles(10);
    d0 = done_cnt;
    push(8'h81);
    host_send(8'h24, 1, 0);
    chk(done_cnt == d0 && last_rx == 8'h24, "R5", "receive before send", done_cnt - d0, 0);
    wait_done(d0 + 1, "R5");
    wait_cycles(40);
    chk(frames_ok == 7, "R5", "waiting byte sent afterwards", frames_ok, 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule